// File: doc/BRIEF.md
# Multi-mode operand fetch sequencer

This block is the control engine of a small 32-bit processor core. It runs one instruction at a time. It holds sixteen 32-bit general registers, and the top register serves as the program counter. All traffic goes through one word-addressed memory port. For each instruction it fetches a word at the program counter and advances the counter. It then gathers the first operand, A, and the second operand, B. Each operand uses one of four register addressing modes, and A may instead be a short signed constant. The sequencer hands both operands to an arithmetic unit outside the block. It keeps a four-bit status word (carry, overflow, negative, zero) and tests it against a store condition. When the test passes, the result goes back to a register or to memory.

Register side effects are applied in a fixed order. The program counter goes first, then the register named by A, then the register named by B, and the result comes last. Each step reads the register file as the earlier steps have left it. Every memory access is a request that is held until the memory answers with a ready strobe. A one-cycle completion pulse marks the end of each instruction.

Top module: `opf_seq`

## Requirements
- R1: While reset is asserted and after its release, all sixteen registers and the status word read zero. The first fetch is from address 0, the completion pulse is low and no write is requested.
- R2: Instruction fields: bits 3:0 name register A and bits 5:4 give mode A. Bit 9 selects the constant, which occupies bits 8:0. Bits 13:10 name register B and bits 15:14 give mode B. Bits 19:16 are the status update mask, bits 23:20 the store condition and bits 27:24 the operation code passed to the arithmetic unit.
- R3: The instruction is read at the address held in register 15. Register 15 is incremented before operand A is gathered, so a reference to register 15 by either operand sees the incremented value.
- R4: When bit 9 is set, operand A is bits 8:0 sign-extended to 32 bits and no register is changed for A.
- R5: Mode codes: 00 means the operand is the register itself. 01 means memory at the register. 10 means memory at register minus one, and the decremented value is written back. 11 means memory at the register, and the register plus one is written back.
- R6: Operand B reads its register after A's write-back. The address B used, after any decrement, is kept as the store address.
- R7: The store condition is decided on the status word as it stood before this instruction. With c,v,n,z the status bits, codes 0..15 pass on ~c, c, ~v, v, ~n, n, ~z, z, ~c&~z, c|z, n==v, n!=v, ~z&(n==v), z|(n!=v), always, never.
- R8: When the condition passes and mode B is 00, the result is written to register B. When it passes and mode B is any other mode, the result is written to memory at the kept address. When it fails, nothing is stored, but the register write-backs made for A and B remain.
- R9: The arithmetic unit's status input is ordered {c,v,n,z} in bits 3..0. Mask bit 16 updates z, bit 17 n, bit 18 v and bit 19 c; unmasked bits keep their value. The carry output to the unit is the stored c.
- R10: At most one of read and write is requested at a time. A request holds its address and data steady until ready is seen high at a clock edge, and no state advances while it waits.
- R11: The completion pulse is high for exactly one cycle per instruction, in the cycle after the last register or memory update. The next fetch request is presented in that same cycle.
- R12: Bits 31:28 of the instruction word have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| mem_addr | output | 32 | Word address of the current memory request |
| mem_rd | output | 1 | Read request |
| mem_wr | output | 1 | Write request |
| mem_wdata | output | 32 | Data for a write request |
| mem_rdata | input | 32 | Read data, taken in the cycle ready is high |
| mem_ready | input | 1 | Memory completes the pending request at this edge |
| alu_op | output | 4 | Operation code for the arithmetic unit |
| alu_a | output | 32 | Operand A |
| alu_b | output | 32 | Operand B |
| alu_cin | output | 1 | Stored carry bit |
| alu_res | input | 32 | Result from the arithmetic unit |
| alu_flg | input | 4 | Status from the arithmetic unit, {c,v,n,z} |
| done | output | 1 | One-cycle pulse when an instruction completes |

## Verification
The assertions assume that the memory answers in the same cycle that ready is high and may hold ready low for any number of cycles. They also assume that the arithmetic unit is purely combinational and settles within the cycle its operands are shown. The stimulus keeps to this. The memory model stalls at random on about one request in four and returns data from a plain array. The arithmetic unit is a function of the outputs it sees. Random programs are run from a fully random memory image, so wild pointers, self-modifying code and jumps through register 15 occur. All addresses wrap inside a 256-word window, and the reference interpreter uses that same window.

// File: rtl/opf_pkg.sv
package opf_pkg;

  localparam int IW_BITS = 28;
  localparam int IMM_W   = 9;

  typedef enum logic [1:0] {
    AM_DIRECT  = 2'b00,
    AM_IND     = 2'b01,
    AM_PREDEC  = 2'b10,
    AM_POSTINC = 2'b11
  } amode_t;

  typedef enum logic [2:0] {
    ST_FETCH,
    ST_OPA,
    ST_AMEM,
    ST_OPB,
    ST_BMEM,
    ST_EXEC,
    ST_STORE
  } seq_state_t;

  // status word, bit order {c,v,n,z}
  typedef struct packed {
    logic c;
    logic v;
    logic n;
    logic z;
  } flags_t;

  // bits 27:0 of an instruction word; the top nibble is never kept
  typedef struct packed {
    logic [3:0] op;
    logic [3:0] cond;
    logic [3:0] mask;
    amode_t     mb;
    logic [3:0] rb;
    logic       imm_sel;
    logic [2:0] hi;
    amode_t     ma;
    logic [3:0] ra;
  } instr_t;

endpackage

// File: rtl/opf_regfile.sv
module opf_regfile #(
  parameter int XLEN = 32,
  parameter int NREG = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [$clog2(NREG)-1:0] waddr,
  input  logic [XLEN-1:0]         wdata,
  input  logic [$clog2(NREG)-1:0] raddr,
  output logic [XLEN-1:0]         rdata,
  output logic [XLEN-1:0]         pc
);
  localparam int RW = $clog2(NREG);

  logic [XLEN-1:0] regs_q [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (we && (waddr == RW'(i))) regs_q[i] <= wdata;
      end
    end
  end

  assign rdata = regs_q[raddr];
  assign pc    = regs_q[NREG-1];

endmodule

// File: rtl/opf_cond.sv
module opf_cond
  import opf_pkg::*;
(
  input  logic [3:0] code,
  input  flags_t     flg,
  output logic       pass
);
  logic nv_eq;

  always_comb begin
    nv_eq = (flg.n == flg.v);
    unique case (code)
      4'd0:    pass = ~flg.c;
      4'd1:    pass =  flg.c;
      4'd2:    pass = ~flg.v;
      4'd3:    pass =  flg.v;
      4'd4:    pass = ~flg.n;
      4'd5:    pass =  flg.n;
      4'd6:    pass = ~flg.z;
      4'd7:    pass =  flg.z;
      4'd8:    pass = ~flg.c & ~flg.z;
      4'd9:    pass =  flg.c |  flg.z;
      4'd10:   pass =  nv_eq;
      4'd11:   pass = ~nv_eq;
      4'd12:   pass = ~flg.z &  nv_eq;
      4'd13:   pass =  flg.z | ~nv_eq;
      4'd14:   pass = 1'b1;
      default: pass = 1'b0;
    endcase
  end

endmodule

// File: rtl/opf_seq.sv
module opf_seq
  import opf_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [XLEN-1:0] mem_addr,
  output logic            mem_rd,
  output logic            mem_wr,
  output logic [XLEN-1:0] mem_wdata,
  input  logic [XLEN-1:0] mem_rdata,
  input  logic            mem_ready,
  output logic [3:0]      alu_op,
  output logic [XLEN-1:0] alu_a,
  output logic [XLEN-1:0] alu_b,
  output logic            alu_cin,
  input  logic [XLEN-1:0] alu_res,
  input  logic [3:0]      alu_flg,
  output logic            done
);
  localparam int NREG   = 16;
  localparam int RW     = $clog2(NREG);
  localparam int PC_IDX = NREG - 1;
  localparam logic [XLEN-1:0] ONE = XLEN'(1);

  seq_state_t st_q, st_d;
  instr_t     ir_q;
  flags_t     flg_q, flg_d;
  logic [XLEN-1:0] opa_q, opb_q, addr_q, res_q;
  logic [XLEN-1:0] opnd_d, addr_d, imm_ext, ptr_dec, ptr_inc;
  logic ir_en, opa_en, opb_en, addr_en, res_en, flg_en, done_d, done_q;

  logic            rf_we;
  logic [RW-1:0]   rf_waddr, rf_raddr;
  logic [XLEN-1:0] rf_wdata, rf_rdata, pc_val;
  amode_t          mode_cur;
  logic            store_ok, in_opnd, ptr_wb;

  opf_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (rf_we),
    .waddr (rf_waddr),
    .wdata (rf_wdata),
    .raddr (rf_raddr),
    .rdata (rf_rdata),
    .pc    (pc_val)
  );

  opf_cond u_cond (
    .code (ir_q.cond),
    .flg  (flg_q),
    .pass (store_ok)
  );

  // operand datapath shared by the A and B stages
  always_comb begin
    in_opnd  = (st_q == ST_OPA) || (st_q == ST_OPB);
    mode_cur = (st_q == ST_OPA) ? ir_q.ma : ir_q.mb;
    rf_raddr = (st_q == ST_OPA) ? ir_q.ra : ir_q.rb;
    ptr_dec  = rf_rdata - ONE;
    ptr_inc  = rf_rdata + ONE;
    imm_ext  = {{(XLEN-IMM_W){ir_q.hi[2]}}, ir_q.hi, ir_q.ma, ir_q.ra};
    if (st_q == ST_AMEM || st_q == ST_BMEM)       opnd_d = mem_rdata;
    else if (st_q == ST_OPA && ir_q.imm_sel)      opnd_d = imm_ext;
    else                                          opnd_d = rf_rdata;
    addr_d   = (mode_cur == AM_PREDEC) ? ptr_dec : rf_rdata;
    ptr_wb   = in_opnd && !(st_q == ST_OPA && ir_q.imm_sel) &&
               (mode_cur == AM_PREDEC || mode_cur == AM_POSTINC);
    flg_d    = flags_t'((alu_flg & ir_q.mask) | (flg_q & ~ir_q.mask));
  end

  // next-state and control
  always_comb begin
    st_d      = st_q;
    ir_en     = 1'b0;
    opa_en    = 1'b0;
    opb_en    = 1'b0;
    addr_en   = 1'b0;
    res_en    = 1'b0;
    flg_en    = 1'b0;
    done_d    = 1'b0;
    mem_rd    = 1'b0;
    mem_wr    = 1'b0;
    mem_addr  = addr_q;
    mem_wdata = res_q;
    rf_we     = 1'b0;
    rf_waddr  = rf_raddr;
    rf_wdata  = (mode_cur == AM_PREDEC) ? ptr_dec : ptr_inc;
    unique case (st_q)
      ST_FETCH: begin
        mem_rd   = 1'b1;
        mem_addr = pc_val;
        if (mem_ready) begin
          ir_en    = 1'b1;
          rf_we    = 1'b1;
          rf_waddr = RW'(PC_IDX);
          rf_wdata = pc_val + ONE;
          st_d     = ST_OPA;
        end
      end
      ST_OPA: begin
        if (ir_q.imm_sel || mode_cur == AM_DIRECT) begin
          opa_en = 1'b1;
          st_d   = ST_OPB;
        end else begin
          addr_en = 1'b1;
          rf_we   = ptr_wb;
          st_d    = ST_AMEM;
        end
      end
      ST_AMEM: begin
        mem_rd = 1'b1;
        if (mem_ready) begin
          opa_en = 1'b1;
          st_d   = ST_OPB;
        end
      end
      ST_OPB: begin
        if (mode_cur == AM_DIRECT) begin
          opb_en = 1'b1;
          st_d   = ST_EXEC;
        end else begin
          addr_en = 1'b1;
          rf_we   = ptr_wb;
          st_d    = ST_BMEM;
        end
      end
      ST_BMEM: begin
        mem_rd = 1'b1;
        if (mem_ready) begin
          opb_en = 1'b1;
          st_d   = ST_EXEC;
        end
      end
      ST_EXEC: begin
        flg_en = 1'b1;
        if (store_ok && ir_q.mb == AM_DIRECT) begin
          rf_we    = 1'b1;
          rf_waddr = ir_q.rb;
          rf_wdata = alu_res;
          done_d   = 1'b1;
          st_d     = ST_FETCH;
        end else if (store_ok) begin
          res_en = 1'b1;
          st_d   = ST_STORE;
        end else begin
          done_d = 1'b1;
          st_d   = ST_FETCH;
        end
      end
      ST_STORE: begin
        mem_wr = 1'b1;
        if (mem_ready) begin
          done_d = 1'b1;
          st_d   = ST_FETCH;
        end
      end
      default: st_d = ST_FETCH;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_FETCH;
      ir_q   <= '0;
      opa_q  <= '0;
      opb_q  <= '0;
      addr_q <= '0;
      res_q  <= '0;
      flg_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
      if (ir_en)   ir_q   <= instr_t'(mem_rdata[IW_BITS-1:0]);
      if (opa_en)  opa_q  <= opnd_d;
      if (opb_en)  opb_q  <= opnd_d;
      if (addr_en) addr_q <= addr_d;
      if (res_en)  res_q  <= alu_res;
      if (flg_en)  flg_q  <= flg_d;
    end
  end

  assign alu_op  = ir_q.op;
  assign alu_a   = opa_q;
  assign alu_b   = opb_q;
  assign alu_cin = flg_q.c;
  assign done    = done_q;

  // R10: never read and write together
  a_r10_one_access: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));
  // R10: a stalled read keeps its address
  a_r10_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && !mem_ready) |=> (mem_rd && $stable(mem_addr)));
  // R10: a stalled write keeps address and data
  a_r10_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && !mem_ready) |=> (mem_wr && $stable(mem_addr) && $stable(mem_wdata)));
  // R8: a completed memory store ends the instruction
  a_r8_store_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && mem_ready) |=> done);
  // R11: completion is a single-cycle pulse
  a_r11_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R11: next fetch is presented alongside the pulse
  a_r11_refetch: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (mem_rd && mem_addr == pc_val));
  // R3: an accepted fetch advances the program counter by one
  a_r3_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_FETCH && mem_ready) |=> (pc_val == $past(pc_val) + ONE));
  // R4: the constant path leaves the program counter alone
  a_r4_imm_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_OPA && ir_q.imm_sel) |=> (st_q == ST_OPB && $stable(pc_val)));

endmodule

// File: tb/opf_seq_test.sv
`timescale 1ns/1ps
module opf_seq_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_rd, mem_wr, mem_ready;
  logic [3:0]  alu_op, alu_flg;
  logic [31:0] alu_a, alu_b, alu_res;
  logic        alu_cin, done;

  int total = 0;
  int bad   = 0;

  logic [31:0] dmem [256];
  logic [31:0] rmem [256];
  logic [31:0] m_r  [16];
  logic [3:0]  m_f;
  logic        pend;
  logic [7:0]  pa;
  logic [31:0] pd;

  always #10 clk = ~clk;

  opf_seq uut (
    .clk(clk), .rst_n(rst_n),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .alu_op(alu_op), .alu_a(alu_a), .alu_b(alu_b), .alu_cin(alu_cin),
    .alu_res(alu_res), .alu_flg(alu_flg), .done(done)
  );

  // environment arithmetic unit: returns {c,v,n,z,result}
  function automatic logic [35:0] alu_model(input logic [3:0] op, input logic [31:0] a,
                                            input logic [31:0] b, input logic ci);
    logic [32:0] s;
    logic [31:0] r;
    logic c, v;
    s = '0; c = 1'b0; v = 1'b0;
    case (op)
      4'd1:  begin s = {1'b0, a} + 33'd1; r = s[31:0]; c = s[32]; end
      4'd2:  begin s = {1'b0, a} + {1'b0, b} + {32'd0, ci}; r = s[31:0]; c = s[32];
                   v = (a[31] == b[31]) && (r[31] != a[31]); end
      4'd3:  begin s = {1'b0, a} + {1'b0, b}; r = s[31:0]; c = s[32];
                   v = (a[31] == b[31]) && (r[31] != a[31]); end
      4'd4:  begin s = 33'd0 - {1'b0, a}; r = s[31:0]; c = s[32]; end
      4'd5:  begin s = {1'b0, a} - 33'd1; r = s[31:0]; c = s[32]; end
      4'd6:  begin s = {1'b0, b} - {1'b0, a} - {32'd0, ci}; r = s[31:0]; c = s[32];
                   v = (a[31] != b[31]) && (r[31] != b[31]); end
      4'd7:  begin s = {1'b0, b} - {1'b0, a}; r = s[31:0]; c = s[32];
                   v = (a[31] != b[31]) && (r[31] != b[31]); end
      4'd8:  begin r = {ci, a[31:1]};    c = a[0]; end
      4'd9:  begin r = {a[31], a[31:1]}; c = a[0]; end
      4'd10: begin r = {1'b0, a[31:1]};  c = a[0]; end
      4'd11: r = b ^ a;
      4'd12: r = b | a;
      4'd13: r = b & a;
      4'd14: r = ~a;
      default: r = a;
    endcase
    return {c, v, r[31], (r == 32'd0), r};
  endfunction

  assign {alu_flg, alu_res} = alu_model(alu_op, alu_a, alu_b, alu_cin);
  assign mem_rdata = dmem[mem_addr[7:0]];

  // R7: reference store condition, status packed {c,v,n,z}
  function automatic logic cond_ref(input logic [3:0] cc, input logic [3:0] f);
    logic c, v, n, z;
    {c, v, n, z} = f;
    case (cc)
      4'd0: return !c;         4'd1: return c;
      4'd2: return !v;         4'd3: return v;
      4'd4: return !n;         4'd5: return n;
      4'd6: return !z;         4'd7: return z;
      4'd8: return !(c || z);  4'd9: return c || z;
      4'd10: return n ~^ v;    4'd11: return n ^ v;
      4'd12: return !z && (n ~^ v);
      4'd13: return z || (n ^ v);
      4'd14: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // R2 field layout, R5 modes, R6 ordering, R8 destination, R9 mask, R12 top nibble
  task automatic model_step();
    logic [31:0] ins, v, a, b, badr;
    logic [35:0] o;
    logic [3:0] ra, rb;
    logic [1:0] ma, mb;
    ins = rmem[m_r[15][7:0]];
    m_r[15] = m_r[15] + 32'd1;
    ra = ins[3:0];   ma = ins[5:4];
    rb = ins[13:10]; mb = ins[15:14];
    if (ins[9]) a = {{23{ins[8]}}, ins[8:0]};
    else begin
      v = m_r[ra];
      case (ma)
        2'b00: a = v;
        2'b01: a = rmem[v[7:0]];
        2'b10: begin a = rmem[(v - 32'd1) & 32'hFF]; m_r[ra] = v - 32'd1; end
        default: begin a = rmem[v[7:0]]; m_r[ra] = v + 32'd1; end
      endcase
    end
    v = m_r[rb];
    badr = (mb == 2'b10) ? v - 32'd1 : v;
    b = (mb == 2'b00) ? v : rmem[badr[7:0]];
    if (mb == 2'b10) m_r[rb] = v - 32'd1;
    if (mb == 2'b11) m_r[rb] = v + 32'd1;
    o = alu_model(ins[27:24], a, b, m_f[3]);
    if (cond_ref(ins[23:20], m_f)) begin
      if (mb == 2'b00) m_r[rb] = o[31:0];
      else rmem[badr[7:0]] = o[31:0];
    end
    m_f = (o[35:32] & ins[19:16]) | (m_f & ~ins[19:16]);
  endtask

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    if (pend) dmem[pa] = pd;
    mem_ready = ($urandom % 4) != 0;
    pend = mem_wr && mem_ready;
    pa   = mem_addr[7:0];
    pd   = mem_wdata;
  endtask

  task automatic model_reset();
    for (int i = 0; i < 16; i++) m_r[i] = 32'd0;
    m_f = 4'd0;
    for (int i = 0; i < 256; i++) rmem[i] = dmem[i];
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    tick();
    tick();
    // R1: reset state seen at the ports
    chk(done == 1'b0, "R1 done low in reset", {31'd0, done}, 32'd0);
    chk(mem_wr == 1'b0, "R1 no write in reset", {31'd0, mem_wr}, 32'd0);
    chk(mem_rd && mem_addr == 32'd0, "R1 first fetch at 0", mem_addr, 32'd0);
    rst_n = 1'b1;
    model_reset();
  endtask

  function automatic logic [31:0] mk(input int op, input int cc, input int sf, input int mb,
                                     input int rb, input bit imm, input logic [8:0] lo);
    return {4'd0, op[3:0], cc[3:0], sf[3:0], mb[1:0], rb[3:0], imm, lo};
  endfunction

  task automatic run_prog(input int n, input bit directed);
    for (int i = 0; i < n; i++) begin
      bit got;
      int wrong;
      got = 1'b0;
      for (int t = 0; t < 600 && !got; t++) begin
        tick();
        if (done) got = 1'b1;
      end
      chk(got, "R11 completion pulse within bound", {31'd0, got}, 32'd1);
      if (!got) return;
      model_step();
      wrong = -1;
      for (int j = 0; j < 256; j++) if (wrong < 0 && dmem[j] !== rmem[j]) wrong = j;
      chk(wrong < 0, "R8 R10 memory image", (wrong < 0) ? 32'd0 : dmem[wrong],
          (wrong < 0) ? 32'd0 : rmem[wrong]);
      chk(mem_rd && mem_addr == m_r[15], "R3 next fetch address", mem_addr, m_r[15]);
      if (directed) begin
        case (i)
          2:  chk(dmem[99] == 32'hFFFF_FFFB, "R4 sign-extended constant", dmem[99], 32'hFFFF_FFFB);
          4:  chk(dmem[99] == 32'd3, "R5 R6 pre-decrement then indirect", dmem[99], 32'd3);
          6:  chk(dmem[100] == 32'd9, "R8 side effect kept on failed store", dmem[100], 32'd9);
          8:  chk(dmem[100] == 32'd1, "R7 R9 zero condition passes", dmem[100], 32'd1);
          9:  chk(dmem[100] == 32'd1, "R7 not-zero condition blocks store", dmem[100], 32'd1);
          11: chk(dmem[100] == 32'd3, "R12 top nibble ignored", dmem[100], 32'd3);
          default: ;
        endcase
      end
      tick();
      chk(!done, "R11 pulse lasts one cycle", {31'd0, done}, 32'd0);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    pend = 1'b0;
    pa = '0;
    pd = '0;
    mem_ready = 1'b0;
    rst_n = 1'b0;
    for (int i = 0; i < 256; i++) dmem[i] = 32'd0;
    // directed program
    dmem[0]  = mk(0, 14, 0, 0, 1, 1, 9'h1FB);
    dmem[1]  = mk(0, 14, 0, 0, 2, 1, 9'd100);
    dmem[2]  = mk(0, 14, 0, 2, 2, 0, {3'b0, 2'b00, 4'd1});
    dmem[3]  = mk(3, 14, 0, 3, 2, 1, 9'd7);
    dmem[4]  = mk(1, 14, 0, 1, 2, 0, {3'b0, 2'b10, 4'd2});
    dmem[5]  = mk(0, 15, 0, 3, 2, 1, 9'd5);
    dmem[6]  = mk(0, 14, 0, 1, 2, 1, 9'd9);
    dmem[7]  = mk(0, 14, 15, 0, 3, 1, 9'd0);
    dmem[8]  = mk(0, 7, 0, 1, 2, 1, 9'd1);
    dmem[9]  = mk(0, 6, 0, 1, 2, 1, 9'd2);
    dmem[10] = mk(0, 14, 0, 0, 4, 1, 9'd3) | 32'hF000_0000;
    dmem[11] = mk(0, 14, 0, 1, 2, 0, {3'b0, 2'b00, 4'd4});
    do_reset();
    run_prog(12, 1'b1);
    // random programs from a random image, reset mid-stream
    for (int k = 0; k < 4; k++) begin
      for (int i = 0; i < 256; i++) dmem[i] = $urandom;
      do_reset();
      run_prog(100, 1'b0);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule